// File: doc/BRIEF.md
# Flat Page Table Address Translator

This block turns 32-bit device virtual addresses into physical addresses. It uses a single-level page table that sits in memory and is indexed directly by the 4 KB page number. A base register gives the table's location. A table lookup fetches one 32-bit descriptor through a simple read port. The descriptor holds a 20-bit frame number in bits [31:12], a valid flag in bit 1 and a non-secure flag in bit 3. Results that translate are kept in a small fully associative TLB that uses round-robin replacement.

A client hands over a virtual address with a valid/ready handshake. One cycle later it gets back either a physical address or a fault. Only one table read is in flight at a time, and new requests are held off while it completes. Software uses a small word-indexed register port to set the table base and to flush the TLB, either fully or over an inclusive page range. The register port also has a completion flag that software can clear.

Top module: `flatpt_xlate`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o and mem_req_o are 0, and every register reads 0. Register word indices are 0 table base, 1 invalidate select, 2 range start, 3 range end, 4 command (reads 0), 5 range-done flag.
- R2: A table read drives mem_addr_o = base + VA[31:12]*4. Base bits [1:0] are dropped on write and read back as 0.
- R3: A descriptor with bit 1 set gives rsp_pa_o = {descriptor[31:12], VA[11:0]}, rsp_ns_o = descriptor bit 3 and rsp_fault_o = 0.
- R4: A descriptor with bit 1 clear, including the all-zero descriptor, gives rsp_fault_o = 1, rsp_pa_o = 0 and rsp_ns_o = 0. It is not cached, so asking again reads the table again.
- R5: A TLB hit responds on the cycle after acceptance with no table read. A miss raises mem_req_o on the cycle after acceptance and responds on the cycle after mem_rvalid_i is captured.
- R6: From the acceptance of a miss until its response, req_ready_o is 0. mem_req_o lasts one cycle per lookup, and mem_rvalid_i is ignored while no lookup is waiting.
- R7: The TLB holds TLB_ENTRIES (8) translations. Fills replace entries in round-robin order, so the ninth distinct page evicts the oldest fill.
- R8: Writing 0x2 to the command register drops every TLB entry.
- R9: Writing 0x1 to the command register drops the entries whose page lies between the start and end pages, both included. Start and end are masked with 0xFFFFF000 on write.
- R10: A range command (0x1) sets the done flag (reads 1) on the next cycle. Writing 0 to index 5 clears it, and other values written there have no effect.
- R11: Invalidation only takes effect when select bits [1:0] are both 1. Command values other than 0x1 and 0x2 do nothing.
- R12: If an invalidation is accepted while a lookup is in flight, the descriptor it returns is still answered but not cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_va_i | input | 32 | Virtual address |
| rsp_valid_o | output | 1 | Response valid for one cycle |
| rsp_pa_o | output | 32 | Physical address (0 on fault) |
| rsp_fault_o | output | 1 | Translation fault |
| rsp_ns_o | output | 1 | Non-secure flag of the translation |
| mem_req_o | output | 1 | Table read strobe |
| mem_addr_o | output | 32 | Table descriptor address |
| mem_rvalid_i | input | 1 | Table read data valid |
| mem_rdata_i | input | 32 | Table descriptor |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |

## Verification
Counting negative edges after the accepting clock edge, a hit answers at the first one. A miss answers at the second one after the memory model's fixed read latency, which is latency plus two in total. The bench measures this number on every request and compares it with the value for the hit or miss it expects. It also samples req_ready_o at the first negative edge after acceptance, which is when a miss has already dropped it. A register write takes effect at the edge that captures it, so read-backs and the done flag are sampled one cycle later through the combinational read port.

// File: rtl/flatpt_pkg.sv
package flatpt_pkg;
  localparam int unsigned AW        = 32;
  localparam int unsigned PG_SHIFT  = 12;
  localparam int unsigned VPN_W     = AW - PG_SHIFT;
  localparam int unsigned ENT_VALID = 1;
  localparam int unsigned ENT_NS    = 3;

  localparam logic [2:0] RA_BASE  = 3'd0;
  localparam logic [2:0] RA_SEL   = 3'd1;
  localparam logic [2:0] RA_START = 3'd2;
  localparam logic [2:0] RA_END   = 3'd3;
  localparam logic [2:0] RA_CMD   = 3'd4;
  localparam logic [2:0] RA_DONE  = 3'd5;

  localparam logic [AW-1:0] CMD_RANGE = 32'h1;
  localparam logic [AW-1:0] CMD_ALL   = 32'h2;

  typedef logic [VPN_W-1:0] vpn_t;

  typedef struct packed {
    logic vld;
    vpn_t vpn;
    vpn_t pfn;
    logic ns;
  } tlb_ent_t;

  typedef enum logic [1:0] {W_IDLE, W_ISSUE, W_WAIT} walk_st_e;
endpackage

// File: rtl/flatpt_regs.sv
module flatpt_regs
  import flatpt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] rdata_o,
  output logic [AW-1:0] base_o,
  output logic          flush_all_o,
  output logic          flush_rng_o,
  output vpn_t          rng_lo_o,
  output vpn_t          rng_hi_o,
  output logic          done_o
);
  logic [AW-1:2] base_q;
  logic [1:0]    sel_q;
  vpn_t          lo_q, hi_q;
  logic          done_q;
  logic          cmd_wr, sel_ok;

  assign cmd_wr      = we_i && (addr_i == RA_CMD);
  assign sel_ok      = &sel_q;
  assign flush_all_o = cmd_wr && sel_ok && (wdata_i == CMD_ALL);
  assign flush_rng_o = cmd_wr && sel_ok && (wdata_i == CMD_RANGE);
  assign base_o      = {base_q, 2'b00};
  assign rng_lo_o    = lo_q;
  assign rng_hi_o    = hi_q;
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      sel_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      done_q <= 1'b0;
    end else begin
      if (we_i) begin
        case (addr_i)
          RA_BASE:  base_q <= wdata_i[AW-1:2];
          RA_SEL:   sel_q  <= wdata_i[1:0];
          RA_START: lo_q   <= wdata_i[AW-1:PG_SHIFT];
          RA_END:   hi_q   <= wdata_i[AW-1:PG_SHIFT];
          RA_DONE:  if (wdata_i == '0) done_q <= 1'b0;
          default: ;
        endcase
      end
      // completion reported regardless of select gating
      if (cmd_wr && (wdata_i == CMD_RANGE)) done_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_BASE:  rdata_o = {base_q, 2'b00};
      RA_SEL:   rdata_o[1:0] = sel_q;
      RA_START: rdata_o = {lo_q, {PG_SHIFT{1'b0}}};
      RA_END:   rdata_o = {hi_q, {PG_SHIFT{1'b0}}};
      RA_DONE:  rdata_o[0] = done_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/flatpt_tlb.sv
module flatpt_tlb
  import flatpt_pkg::*;
#(
  parameter int unsigned ENTRIES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  vpn_t lkp_vpn_i,
  output logic hit_o,
  output vpn_t hit_pfn_o,
  output logic hit_ns_o,
  input  logic fill_en_i,
  input  vpn_t fill_vpn_i,
  input  vpn_t fill_pfn_i,
  input  logic fill_ns_i,
  input  logic flush_all_i,
  input  logic flush_rng_i,
  input  vpn_t rng_lo_i,
  input  vpn_t rng_hi_i
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  tlb_ent_t           ent_q [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] in_rng;
  logic [IDX_W-1:0]   ptr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign hit_vec[g] = ent_q[g].vld && (ent_q[g].vpn == lkp_vpn_i);
    assign in_rng[g]  = (ent_q[g].vpn >= rng_lo_i) && (ent_q[g].vpn <= rng_hi_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[g] <= '0;
      end else if (flush_all_i || (flush_rng_i && in_rng[g])) begin
        ent_q[g].vld <= 1'b0;
      end else if (fill_en_i && (ptr_q == IDX_W'(g))) begin
        ent_q[g] <= '{vld: 1'b1, vpn: fill_vpn_i, pfn: fill_pfn_i, ns: fill_ns_i};
      end
    end
  end

  assign hit_o = |hit_vec;

  always_comb begin
    hit_pfn_o = '0;
    hit_ns_o  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        hit_pfn_o = hit_pfn_o | ent_q[i].pfn;
        hit_ns_o  = hit_ns_o | ent_q[i].ns;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (fill_en_i) ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end
endmodule

// File: rtl/flatpt_walker.sv
module flatpt_walker
  import flatpt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_va_i,
  input  logic          hit_i,
  input  vpn_t          hit_pfn_i,
  input  logic          hit_ns_i,
  input  logic [AW-1:0] base_i,
  input  logic          inv_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          fill_en_o,
  output vpn_t          fill_vpn_o,
  output vpn_t          fill_pfn_o,
  output logic          fill_ns_o,
  output logic          rsp_valid_o,
  output logic [AW-1:0] rsp_pa_o,
  output logic          rsp_fault_o,
  output logic          rsp_ns_o
);
  walk_st_e      st_q;
  logic [AW-1:0] va_q;
  logic          drop_q, ent_ok, accept;
  logic          unused_rdata;

  assign req_ready_o = (st_q == W_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign ent_ok      = mem_rdata_i[ENT_VALID];
  assign mem_req_o   = (st_q == W_ISSUE);
  assign mem_addr_o  = base_i + AW'({va_q[AW-1:PG_SHIFT], 2'b00});
  // invalidation seen during the walk (or at its last cycle) blocks the fill
  assign fill_en_o   = (st_q == W_WAIT) && mem_rvalid_i && ent_ok && !drop_q && !inv_i;
  assign fill_vpn_o  = va_q[AW-1:PG_SHIFT];
  assign fill_pfn_o  = mem_rdata_i[AW-1:PG_SHIFT];
  assign fill_ns_o   = mem_rdata_i[ENT_NS];
  assign unused_rdata = ^{mem_rdata_i[PG_SHIFT-1:ENT_NS+1],
                          mem_rdata_i[ENT_NS-1:ENT_VALID+1],
                          mem_rdata_i[ENT_VALID-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= W_IDLE;
      va_q        <= '0;
      drop_q      <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_pa_o    <= '0;
      rsp_fault_o <= 1'b0;
      rsp_ns_o    <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      case (st_q)
        W_IDLE: begin
          if (accept) begin
            if (hit_i) begin
              rsp_valid_o <= 1'b1;
              rsp_pa_o    <= {hit_pfn_i, req_va_i[PG_SHIFT-1:0]};
              rsp_fault_o <= 1'b0;
              rsp_ns_o    <= hit_ns_i;
            end else begin
              va_q   <= req_va_i;
              drop_q <= 1'b0;
              st_q   <= W_ISSUE;
            end
          end
        end
        W_ISSUE: begin
          drop_q <= drop_q | inv_i;
          st_q   <= W_WAIT;
        end
        W_WAIT: begin
          drop_q <= drop_q | inv_i;
          if (mem_rvalid_i) begin
            st_q        <= W_IDLE;
            rsp_valid_o <= 1'b1;
            rsp_fault_o <= !ent_ok;
            rsp_ns_o    <= ent_ok & mem_rdata_i[ENT_NS];
            rsp_pa_o    <= ent_ok ? {mem_rdata_i[AW-1:PG_SHIFT], va_q[PG_SHIFT-1:0]} : '0;
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flatpt_xlate.sv
module flatpt_xlate
  import flatpt_pkg::*;
#(
  parameter int unsigned TLB_ENTRIES = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] req_va_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_pa_o,
  output logic        rsp_fault_o,
  output logic        rsp_ns_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o
);
  logic [AW-1:0] base;
  logic          flush_all, flush_rng, done;
  vpn_t          rng_lo, rng_hi;
  logic          tlb_hit, hit_ns;
  vpn_t          hit_pfn;
  logic          fill_en, fill_ns;
  vpn_t          fill_vpn, fill_pfn;

  flatpt_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .base_o      (base),
    .flush_all_o (flush_all),
    .flush_rng_o (flush_rng),
    .rng_lo_o    (rng_lo),
    .rng_hi_o    (rng_hi),
    .done_o      (done)
  );

  flatpt_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lkp_vpn_i   (req_va_i[AW-1:PG_SHIFT]),
    .hit_o       (tlb_hit),
    .hit_pfn_o   (hit_pfn),
    .hit_ns_o    (hit_ns),
    .fill_en_i   (fill_en),
    .fill_vpn_i  (fill_vpn),
    .fill_pfn_i  (fill_pfn),
    .fill_ns_i   (fill_ns),
    .flush_all_i (flush_all),
    .flush_rng_i (flush_rng),
    .rng_lo_i    (rng_lo),
    .rng_hi_i    (rng_hi)
  );

  flatpt_walker u_walk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_va_i     (req_va_i),
    .hit_i        (tlb_hit),
    .hit_pfn_i    (hit_pfn),
    .hit_ns_i     (hit_ns),
    .base_i       (base),
    .inv_i        (flush_all | flush_rng),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .fill_en_o    (fill_en),
    .fill_vpn_o   (fill_vpn),
    .fill_pfn_o   (fill_pfn),
    .fill_ns_o    (fill_ns),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_pa_o     (rsp_pa_o),
    .rsp_fault_o  (rsp_fault_o),
    .rsp_ns_o     (rsp_ns_o)
  );
endmodule

// File: rtl/flatpt_checker.sv
module flatpt_checker
  import flatpt_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic [AW-1:0] req_va_i,
  input logic          rsp_valid_o,
  input logic [AW-1:0] rsp_pa_o,
  input logic          rsp_fault_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          reg_we_i,
  input logic [2:0]    reg_addr_i,
  input logic [AW-1:0] reg_wdata_i,
  input logic [AW-1:0] base_i,
  input logic          hit_i,
  input logic          done_i
);
  logic [AW-1:0] va_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) va_seen <= '0;
    else if (req_valid_i && req_ready_o) va_seen <= req_va_i;
  end

  assert_one_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  assert_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  assert_fault_pa_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_pa_o == '0));

  assert_offset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_pa_o[PG_SHIFT-1:0] == va_seen[PG_SHIFT-1:0]));

  assert_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o == base_i + AW'({va_seen[AW-1:PG_SHIFT], 2'b00})));

  assert_hit_lat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && hit_i) |=> (rsp_valid_o && !mem_req_o));

  assert_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == RA_CMD && reg_wdata_i == CMD_RANGE) |=> done_i);
endmodule

bind flatpt_xlate flatpt_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_va_i    (req_va_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_pa_o    (rsp_pa_o),
  .rsp_fault_o (rsp_fault_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .base_i      (base),
  .hit_i       (tlb_hit),
  .done_i      (done)
);

// File: tb/tb_flatpt_xlate.sv
`timescale 1ns/1ps
module tb_flatpt_xlate;
  localparam int          MEM_LAT = 2;
  localparam logic [31:0] BASE    = 32'h8000_0000;
  // {expect table read, virtual address}
  localparam logic [32:0] VEC [9] = '{
    33'h1_0000_1234, 33'h0_0000_1FFC, 33'h1_1234_5678, 33'h0_1234_5004,
    33'h1_0000_F010, 33'h1_0000_F010, 33'h1_0000_E004, 33'h1_FFFF_0ABC,
    33'h0_FFFF_0000};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, rsp_valid, rsp_fault, rsp_ns;
  logic [31:0] req_va = '0, rsp_pa;
  logic mem_req, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;

  int n_chk = 0, n_fail = 0, walks = 0, gen = 0;
  logic [31:0] last_addr = '0;
  bit stray = 1'b0;

  always #4 clk = ~clk;

  flatpt_xlate dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .rsp_valid_o(rsp_valid), .rsp_pa_o(rsp_pa), .rsp_fault_o(rsp_fault), .rsp_ns_o(rsp_ns),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata));

  function automatic logic [31:0] pte(logic [19:0] vpn, int g);
    logic [19:0] pfn;
    pfn = vpn ^ 20'h5A5A5 ^ 20'(g * 32'h01111);
    if (vpn[3:0] == 4'hF) return 32'h0;
    if (vpn[3:0] == 4'hE) return {pfn, 12'h008};
    return {pfn, 8'h00, vpn[0], 3'b010};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: fixed latency table reads, plus a stray data beat on demand
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (stray) begin
        stray = 1'b0;
        mem_rvalid = 1'b1;
        mem_rdata  = 32'hDEAD_B00A;
      end else if (mem_req) begin
        last_addr = mem_addr;
        walks++;
        repeat (MEM_LAT) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = pte(20'((last_addr - BASE) >> 2), gen);
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic check_req(logic [31:0] va, int exp_walk, int g, string wtag);
    int w0, lat;
    logic rdy_after;
    logic [31:0] e, exp_pa;
    logic exp_flt;
    string t;
    @(negedge clk);
    req_valid = 1'b1; req_va = va;
    while (!req_ready) @(negedge clk);
    w0 = walks;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    rdy_after = req_ready;
    while (!rsp_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    e = pte(va[31:12], g);
    exp_flt = ~e[1];
    exp_pa  = exp_flt ? 32'h0 : {e[31:12], va[11:0]};
    t = exp_flt ? "R4" : "R3";
    chk({t, " pa"}, rsp_pa, exp_pa);
    chk({t, " fault"}, 32'(rsp_fault), 32'(exp_flt));
    chk({t, " ns"}, 32'(rsp_ns), exp_flt ? 32'h0 : 32'(e[3]));
    chk({wtag, " table reads"}, 32'(walks - w0), 32'(exp_walk));
    chk("R5 latency", 32'(lat), exp_walk != 0 ? 32'(MEM_LAT + 2) : 32'd1);
    chk("R6 ready after accept", 32'(rdy_after), exp_walk != 0 ? 32'd0 : 32'd1);
    if (exp_walk != 0) chk("R2 table address", last_addr, BASE + {10'd0, va[31:12], 2'b00});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    for (int i = 0; i < 6; i++) begin
      rd(3'(i), d);
      chk("R1 register", d, 32'h0);
    end
    // R2 base low bits dropped
    wr(3'd0, BASE | 32'h3);
    rd(3'd0, d);
    chk("R2 base readback", d, BASE);
    wr(3'd1, 32'h3);

    for (int i = 0; i < 9; i++)
      check_req(VEC[i][31:0], int'(VEC[i][32]), gen, VEC[i][32] ? "R4/miss R5" : "R5");

    // R6 stray read data while idle
    @(posedge clk) stray = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R6 stray rvalid", 32'(rsp_valid), 32'd0);
    check_req(32'h0000_1000, 0, 0, "R6");

    // R8 flush all
    gen = 1;
    wr(3'd4, 32'h2);
    check_req(32'h1234_5678, 1, 1, "R8");

    // R9 range flush, inclusive ends
    for (int k = 0; k < 6; k++) check_req(32'h0020_0000 + 32'(k) * 32'h1000, 1, 1, "R9 fill");
    gen = 2;
    wr(3'd2, 32'h0020_2ABC);
    wr(3'd3, 32'h0020_4FFF);
    rd(3'd2, d); chk("R9 start mask", d, 32'h0020_2000);
    rd(3'd3, d); chk("R9 end mask", d, 32'h0020_4000);
    wr(3'd4, 32'h1);
    rd(3'd5, d); chk("R10 done set", d, 32'h1);
    check_req(32'h0020_1008, 0, 1, "R9 below");
    check_req(32'h0020_5008, 0, 1, "R9 above");
    check_req(32'h0020_2008, 1, 2, "R9 start");
    check_req(32'h0020_4FF0, 1, 2, "R9 end");
    check_req(32'h0020_3000, 1, 2, "R9 inside");

    // R10 done clear
    wr(3'd5, 32'h5);
    rd(3'd5, d); chk("R10 nonzero write", d, 32'h1);
    wr(3'd5, 32'h0);
    rd(3'd5, d); chk("R10 clear", d, 32'h0);

    // R11 select gating and unknown command
    wr(3'd1, 32'h1);
    wr(3'd4, 32'h2);
    check_req(32'h0020_1000, 0, 1, "R11 select");
    wr(3'd1, 32'h3);
    wr(3'd4, 32'h3);
    check_req(32'h0020_5000, 0, 1, "R11 command");
    rd(3'd5, d); chk("R11 done untouched", d, 32'h0);

    // R7 round-robin eviction
    gen = 3;
    wr(3'd4, 32'h2);
    for (int k = 0; k < 9; k++) check_req(32'h0040_0000 + 32'(k) * 32'h1000, 1, 3, "R7 fill");
    check_req(32'h0040_1000, 0, 3, "R7 kept");
    check_req(32'h0040_0000, 1, 3, "R7 evicted");
    check_req(32'h0040_1000, 1, 3, "R7 next victim");

    // R12 invalidation while a read is in flight
    fork
      check_req(32'h0050_0000, 1, 3, "R12 first");
      begin
        wait (mem_req == 1'b1);
        wr(3'd4, 32'h2);
      end
    join
    check_req(32'h0050_0000, 1, 3, "R12 not cached");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule